// File: doc/BRIEF.md
# Small-Integer Iterative CORDIC Engine

This block is a sequential CORDIC unit for narrow signed integer data. It has two modes. In rotation mode it turns an input vector through an input angle. Loading the vector (61, 0) makes the x and y results the cosine and sine of the angle on a scale of roughly ±100. The value 61 is 100 times the six-stage gain of 0.607, so the gain is corrected before the first stage instead of after the last one. In vectoring mode the engine drives y to zero. It returns the angle of the input vector in z and the gain-scaled magnitude in x.

A request is a one-cycle `start_i` pulse that carries the mode and the operands. The engine performs one shift-add micro-rotation per clock. During each micro-rotation it subtracts or adds an arctangent constant from a small table it computes at elaboration time. When the last micro-rotation is complete, it presents saturated results along with a one-cycle `done_o` strobe. The results hold until the next completion. A request that arrives while the engine is working is dropped.

Angles are expressed in units of π/256, which is 1/128 of a right angle. With an 8-bit angle word, the input range covers about ±90°, and this is inside the range where the iterations converge. In vectoring mode the x operand must not be negative.

Top module: `cordic_engine`

## Requirements
- R1: While reset is low and after it is released, `busy_o` and `done_o` are 0 and `x_o`, `y_o` and `z_o` are 0 until the first completion.
- R2: A request is accepted when `start_i` is 1 at a rising edge while `busy_o` is 0. `busy_o` is then 1 for exactly ITERS (6) cycles. `done_o` is 1 for the single cycle that follows, and the new results appear in that same cycle. A request made during that done cycle is accepted.
- R3: While `busy_o` is 1, `start_i` and the operand inputs are ignored: the running result is unchanged and no extra `done_o` pulse occurs.
- R4: Rotation mode (`mode_i` = 0) applies micro-rotation i (i = 0..5) as follows. If the residual z is ≥ 0: x -= y>>>i, y += x>>>i, z -= A[i]. Otherwise the signs are reversed. Both updates use the values held before that step.
- R5: Vectoring mode (`mode_i` = 1) chooses the direction from the sign of y. If y < 0: x -= y>>>i, y += x>>>i, z -= A[i]. Otherwise: x += y>>>i, y -= x>>>i, z += A[i]. The z operand is used as the starting angle and is normally 0.
- R6: The arctangent constants A[0..5] are 64, 38, 20, 10, 5 and 3 units of π/256.
- R7: Internally, x and y carry 2 extra fraction bits (loaded as operand × 4) and 2 extra headroom bits. Each output is the internal value arithmetically shifted right by 2, which rounds toward −∞.
- R8: The `x_o` and `y_o` outputs saturate to the range −128..127.
- R9: z is kept one bit wider than the port internally, and `z_o` saturates to −128..127.
- R10: Between `done_o` pulses, `x_o`, `y_o` and `z_o` do not change.
- R11: In rotation mode with operands (61, 0, θ), `x_o` and `y_o` lie within ±4 of 100·cos θ and 100·sin θ. For θ = 0 the exact result is (100, −2, 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe; honoured only while idle |
| mode_i | input | 1 | 0 = rotation, 1 = vectoring |
| x_i | input | 8 | Signed x operand |
| y_i | input | 8 | Signed y operand |
| z_i | input | 8 | Signed angle operand, units of π/256 |
| busy_o | output | 1 | High while micro-rotations run |
| done_o | output | 1 | One-cycle completion strobe |
| x_o | output | 8 | Signed x result (cosine or magnitude) |
| y_o | output | 8 | Signed y result (sine or residual) |
| z_o | output | 8 | Signed z result (residual or angle) |

## Verification
The bench targets the tie rule at zero residual and the rounding of the guard bits. A vectoring run on (1, 0) yields (2, −1, −12) only if a y of exactly 0 rotates clockwise and the fraction bits are kept. A design that treats zero as negative, or that drops the guard bits, returns different numbers. Saturation is exercised with inputs that push x past 127 or below −128, and with vertical vectors whose accumulated angle reaches ±130. An engine that wraps instead of clamping returns the wrong sign in those cases. Handshake tests issue a second request mid-run and another in the done cycle. A design that restarts on the first, or blocks the second, produces a wrong result, shifts the strobe, or loses an operation.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

   typedef enum logic {
      MODE_ROTATE = 1'b0,
      MODE_VECTOR = 1'b1
   } cordic_mode_e;

   // arctan(2^-i) in units of pi/65536, rounded; rescaled per ANGLE_W by users
   function automatic int atan_fine(input int i);
      int v;
      case (i)
         0:       v = 16384;
         1:       v = 9672;
         2:       v = 5110;
         3:       v = 2594;
         4:       v = 1302;
         5:       v = 652;
         6:       v = 326;
         7:       v = 163;
         default: v = 0;
      endcase
      return v;
   endfunction

   // rounded rescale from pi/65536 units to pi/2^ANGLE_W units
   function automatic int atan_scaled(input int i, input int angle_w);
      return (atan_fine(i) + (1 << (15 - angle_w))) >>> (16 - angle_w);
   endfunction

endpackage

// File: rtl/cordic_seq.sv
module cordic_seq #(
   parameter int ITERS = 6,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   output logic             busy_o,
   output logic             load_o,
   output logic             step_o,
   output logic             last_o,
   output logic [IDX_W-1:0] idx_o
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ITERS - 1);

   logic             busy_q;
   logic [IDX_W-1:0] idx_q;

   assign load_o = start_i & ~busy_q;
   assign step_o = busy_q;
   assign last_o = busy_q & (idx_q == LAST_IDX);
   assign busy_o = busy_q;
   assign idx_o  = idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
      end else if (load_o) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
      end else if (last_o) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
      end else if (step_o) begin
         idx_q  <= idx_q + 1'b1;
      end
   end

endmodule

// File: rtl/cordic_atan_lut.sv
module cordic_atan_lut #(
   parameter int ITERS   = 6,
   parameter int ANGLE_W = 8,
   parameter int ZW      = 9,
   parameter int IDX_W   = 3
) (
   input  logic [IDX_W-1:0]     idx_i,
   output logic signed [ZW-1:0] atan_o
);

   logic signed [ZW-1:0] tab [ITERS];

   for (genvar g = 0; g < ITERS; g++) begin : g_tab
      localparam int VAL = cordic_pkg::atan_scaled(g, ANGLE_W);
      assign tab[g] = ZW'(VAL);
   end

   always_comb begin
      atan_o = '0;
      for (int i = 0; i < ITERS; i++) begin
         if (idx_i == IDX_W'(i)) atan_o = tab[i];
      end
   end

endmodule

// File: rtl/cordic_microrot.sv
module cordic_microrot #(
   parameter int IW    = 12,
   parameter int ZW    = 9,
   parameter int IDX_W = 3
) (
   input  logic                 vec_i,
   input  logic signed [IW-1:0] x_i,
   input  logic signed [IW-1:0] y_i,
   input  logic signed [ZW-1:0] z_i,
   input  logic [IDX_W-1:0]     idx_i,
   input  logic signed [ZW-1:0] atan_i,
   output logic signed [IW-1:0] x_o,
   output logic signed [IW-1:0] y_o,
   output logic signed [ZW-1:0] z_o
);

   logic signed [IW-1:0] x_sh;
   logic signed [IW-1:0] y_sh;
   logic                 ccw;

   assign x_sh = x_i >>> idx_i;
   assign y_sh = y_i >>> idx_i;

   // counter-clockwise step raises y; chosen by y sign or residual angle sign
   assign ccw = vec_i ? y_i[IW-1] : ~z_i[ZW-1];

   always_comb begin
      if (ccw) begin
         x_o = x_i - y_sh;
         y_o = y_i + x_sh;
         z_o = z_i - atan_i;
      end else begin
         x_o = x_i + y_sh;
         y_o = y_i - x_sh;
         z_o = z_i + atan_i;
      end
   end

endmodule

// File: rtl/cordic_sat.sv
module cordic_sat #(
   parameter int IN_W  = 12,
   parameter int OUT_W = 8
) (
   input  logic signed [IN_W-1:0]  d_i,
   output logic signed [OUT_W-1:0] q_o
);

   if (IN_W > OUT_W) begin : g_clamp
      localparam logic signed [IN_W-1:0] HI = IN_W'((1 << (OUT_W - 1)) - 1);
      localparam logic signed [IN_W-1:0] LO = -HI - IN_W'(1);
      always_comb begin
         if (d_i > HI)      q_o = HI[OUT_W-1:0];
         else if (d_i < LO) q_o = LO[OUT_W-1:0];
         else               q_o = d_i[OUT_W-1:0];
      end
   end else begin : g_extend
      assign q_o = OUT_W'(d_i);
   end

endmodule

// File: rtl/cordic_engine.sv
module cordic_engine #(
   parameter int DATA_W  = 8,
   parameter int ANGLE_W = 8,
   parameter int ITERS   = 6,
   parameter int FRAC_W  = 2,
   parameter int HEAD_W  = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic                      mode_i,
   input  logic signed [DATA_W-1:0]  x_i,
   input  logic signed [DATA_W-1:0]  y_i,
   input  logic signed [ANGLE_W-1:0] z_i,
   output logic                      busy_o,
   output logic                      done_o,
   output logic signed [DATA_W-1:0]  x_o,
   output logic signed [DATA_W-1:0]  y_o,
   output logic signed [ANGLE_W-1:0] z_o
);

   import cordic_pkg::*;

   localparam int IW    = DATA_W + HEAD_W + FRAC_W;
   localparam int ZW    = ANGLE_W + 1;
   localparam int IDX_W = (ITERS > 1) ? $clog2(ITERS) : 1;

   if (ITERS < 1 || ITERS > 8) begin : g_bad_iters
      $error("cordic_engine: ITERS must be 1..8");
   end
   if (ANGLE_W < 6 || ANGLE_W > 15) begin : g_bad_angle
      $error("cordic_engine: ANGLE_W must be 6..15");
   end
   if (DATA_W < 4 || FRAC_W < 0 || HEAD_W < 1) begin : g_bad_data
      $error("cordic_engine: DATA_W >= 4, FRAC_W >= 0, HEAD_W >= 1");
   end

   logic                 load, step, last;
   logic [IDX_W-1:0]     idx;
   cordic_mode_e         mode_q;
   logic signed [IW-1:0] x_q, y_q, x_n, y_n, x_int, y_int;
   logic signed [ZW-1:0] z_q, z_n, atan;
   logic signed [DATA_W-1:0]  x_sat, y_sat;
   logic signed [ANGLE_W-1:0] z_sat;
   logic                      done_q;
   logic signed [DATA_W-1:0]  x_oq, y_oq;
   logic signed [ANGLE_W-1:0] z_oq;

   cordic_seq #(.ITERS(ITERS), .IDX_W(IDX_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .busy_o  (busy_o),
      .load_o  (load),
      .step_o  (step),
      .last_o  (last),
      .idx_o   (idx)
   );

   cordic_atan_lut #(.ITERS(ITERS), .ANGLE_W(ANGLE_W), .ZW(ZW), .IDX_W(IDX_W)) u_lut (
      .idx_i  (idx),
      .atan_o (atan)
   );

   cordic_microrot #(.IW(IW), .ZW(ZW), .IDX_W(IDX_W)) u_rot (
      .vec_i  (mode_q == MODE_VECTOR),
      .x_i    (x_q),
      .y_i    (y_q),
      .z_i    (z_q),
      .idx_i  (idx),
      .atan_i (atan),
      .x_o    (x_n),
      .y_o    (y_n),
      .z_o    (z_n)
   );

   // drop the fraction bits, rounding toward minus infinity
   assign x_int = x_n >>> FRAC_W;
   assign y_int = y_n >>> FRAC_W;

   cordic_sat #(.IN_W(IW), .OUT_W(DATA_W)) u_sat_x (.d_i(x_int), .q_o(x_sat));
   cordic_sat #(.IN_W(IW), .OUT_W(DATA_W)) u_sat_y (.d_i(y_int), .q_o(y_sat));
   cordic_sat #(.IN_W(ZW), .OUT_W(ANGLE_W)) u_sat_z (.d_i(z_n), .q_o(z_sat));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_q    <= '0;
         y_q    <= '0;
         z_q    <= '0;
         mode_q <= MODE_ROTATE;
      end else if (load) begin
         x_q    <= IW'(x_i) <<< FRAC_W;
         y_q    <= IW'(y_i) <<< FRAC_W;
         z_q    <= ZW'(z_i);
         mode_q <= cordic_mode_e'(mode_i);
      end else if (step) begin
         x_q    <= x_n;
         y_q    <= y_n;
         z_q    <= z_n;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         x_oq   <= '0;
         y_oq   <= '0;
         z_oq   <= '0;
      end else begin
         done_q <= last;
         if (last) begin
            x_oq <= x_sat;
            y_oq <= y_sat;
            z_oq <= z_sat;
         end
      end
   end

   assign done_o = done_q;
   assign x_o    = x_oq;
   assign y_o    = y_oq;
   assign z_o    = z_oq;

endmodule

// File: rtl/cordic_engine_chk.sv
module cordic_engine_chk #(
   parameter int DATA_W  = 8,
   parameter int ANGLE_W = 8,
   parameter int ITERS   = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start_i,
   input logic               busy_o,
   input logic               done_o,
   input logic [DATA_W-1:0]  x_o,
   input logic [DATA_W-1:0]  y_o,
   input logic [ANGLE_W-1:0] z_o
);

   int run_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)      run_cnt <= 0;
      else if (busy_o) run_cnt <= run_cnt + 1;
      else             run_cnt <= 0;
   end

   AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o |=> busy_o); // R2
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R2
   AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (run_cnt == ITERS) && !busy_o); // R2
   AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> run_cnt < ITERS); // R3
   AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(x_o) && $stable(y_o) && $stable(z_o)); // R10

endmodule

bind cordic_engine cordic_engine_chk #(.DATA_W(DATA_W), .ANGLE_W(ANGLE_W), .ITERS(ITERS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .busy_o  (busy_o),
   .done_o  (done_o),
   .x_o     (x_o),
   .y_o     (y_o),
   .z_o     (z_o)
);

// File: tb/cordic_engine_tb.sv
module cordic_engine_tb;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic              mode_i = 1'b0;
   logic signed [7:0] x_i = '0, y_i = '0, z_i = '0;
   logic              busy_o, done_o;
   logic signed [7:0] x_o, y_o, z_o;

   int n_checks = 0;
   int n_errs   = 0;
   bit finished = 1'b0;

   always #5ns clk = ~clk;

   cordic_engine u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .x_i(x_i), .y_i(y_i), .z_i(z_i), .busy_o(busy_o), .done_o(done_o),
      .x_o(x_o), .y_o(y_o), .z_o(z_o)
   );

   task automatic check_eq(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errs++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int clamp8(input int v);
      return (v > 127) ? 127 : (v < -128) ? -128 : v;
   endfunction

   // reference built from the requirement text (R4..R9)
   task automatic model(input bit vec, input int xi, input int yi, input int zi,
                        output int xo, output int yo, output int zo);
      int at [6] = '{64, 38, 20, 10, 5, 3};
      int x = xi * 4;
      int y = yi * 4;
      int z = zi;
      for (int i = 0; i < 6; i++) begin
         int dx = x >>> i;
         int dy = y >>> i;
         bit ccw = vec ? (y < 0) : (z >= 0);
         if (ccw) begin x = x - dy; y = y + dx; z = z - at[i]; end
         else     begin x = x + dy; y = y - dx; z = z + at[i]; end
      end
      xo = clamp8(x >>> 2);
      yo = clamp8(y >>> 2);
      zo = clamp8(z);
   endtask

   // drive at a falling edge, hold over one rising edge
   task automatic launch(input bit vec, input int x, input int y, input int z);
      start_i = 1'b1; mode_i = vec;
      x_i = 8'(x); y_i = 8'(y); z_i = 8'(z);
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_done(output int k);
      k = 0;
      while (!done_o && k < 30) begin
         @(negedge clk);
         k++;
      end
   endtask

   task automatic run_one(input string req, input bit vec, input int x, input int y, input int z);
      int k, ex, ey, ez;
      model(vec, x, y, z, ex, ey, ez);
      launch(vec, x, y, z);
      check_eq("R2", "busy after accept", int'(busy_o), 1);
      wait_done(k);
      check_eq("R2", "done latency", k, 6);
      check_eq(req, "x_o", int'(x_o), ex);
      check_eq(req, "y_o", int'(y_o), ey);
      check_eq(req, "z_o", int'(z_o), ez);
      @(negedge clk);
      check_eq("R2", "done one cycle", int'(done_o), 0);
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      check_eq("R1", "busy in reset", int'(busy_o), 0);
      check_eq("R1", "done in reset", int'(done_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_eq("R1", "x_o after reset", int'(x_o), 0);
      check_eq("R1", "y_o after reset", int'(y_o), 0);
      check_eq("R1", "z_o after reset", int'(z_o), 0);
      check_eq("R1", "done after reset", int'(done_o), 0);
   endtask

   task automatic t_anchor;
      run_one("R11", 1'b0, 61, 0, 0);
      check_eq("R11", "cos0 exact", int'(x_o), 100);
      check_eq("R11", "sin0 exact", int'(y_o), -2);
      run_one("R7", 1'b1, 1, 0, 0);
      check_eq("R7", "guard x", int'(x_o), 2);
      check_eq("R7", "guard y", int'(y_o), -1);
      check_eq("R6", "angle sum", int'(z_o), -12);
   endtask

   task automatic t_rotate;
      int ang [6] = '{40, -40, 64, -64, 100, -90};
      foreach (ang[j]) begin
         real th;
         int ec, es, dc, ds;
         run_one("R4", 1'b0, 61, 0, ang[j]);
         th = real'(ang[j]) * 3.14159265 / 256.0;
         ec = int'(100.0 * $cos(th));
         es = int'(100.0 * $sin(th));
         dc = int'(x_o) - ec; ds = int'(y_o) - es;
         check_eq("R11", "cos within 4", int'(dc <= 4 && dc >= -4), 1);
         check_eq("R11", "sin within 4", int'(ds <= 4 && ds >= -4), 1);
      end
      run_one("R4", 1'b0, 50, -30, 20);
      run_one("R6", 1'b0, -20, 70, -110);
   endtask

   task automatic t_vector;
      run_one("R5", 1'b1, 80, 0, 0);
      run_one("R5", 1'b1, 60, 60, 0);
      run_one("R5", 1'b1, 100, -40, 0);
      run_one("R5", 1'b1, 30, 90, 0);
      run_one("R5", 1'b1, 45, -12, 10);
   endtask

   task automatic t_saturate;
      run_one("R8", 1'b1, 127, 127, 0);
      check_eq("R8", "x clamp high", int'(x_o), 127);
      run_one("R8", 1'b0, -128, -128, 0);
      check_eq("R8", "x clamp low", int'(x_o), -128);
      run_one("R9", 1'b1, 0, 127, 0);
      check_eq("R9", "z clamp high", int'(z_o), 127);
      run_one("R9", 1'b1, 0, -127, 0);
      check_eq("R9", "z clamp low", int'(z_o), -128);
   endtask

   task automatic t_busy_ignore;
      int k, ex, ey, ez, extra;
      model(1'b0, 61, 0, 32, ex, ey, ez);
      launch(1'b0, 61, 0, 32);
      start_i = 1'b1; mode_i = 1'b1; x_i = 8'sd5; y_i = -8'sd100; z_i = 8'sd77;
      @(negedge clk);
      start_i = 1'b0;
      check_eq("R3", "still busy", int'(busy_o), 1);
      wait_done(k);
      check_eq("R3", "latency unchanged", k, 5);
      check_eq("R3", "x_o", int'(x_o), ex);
      check_eq("R3", "y_o", int'(y_o), ey);
      check_eq("R3", "z_o", int'(z_o), ez);
      extra = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (done_o || busy_o) extra++;
      end
      check_eq("R3", "no second run", extra, 0);
   endtask

   task automatic t_back_to_back;
      int k, ex, ey, ez;
      launch(1'b1, 90, 20, 0);
      wait_done(k);
      model(1'b0, 61, 0, -50, ex, ey, ez);
      launch(1'b0, 61, 0, -50);
      check_eq("R2", "accept in done cycle", int'(busy_o), 1);
      wait_done(k);
      check_eq("R2", "second latency", k, 6);
      check_eq("R2", "second x", int'(x_o), ex);
      check_eq("R2", "second y", int'(y_o), ey);
   endtask

   task automatic t_hold;
      int hx, hy, hz, moved;
      run_one("R10", 1'b0, 61, 0, 25);
      hx = int'(x_o); hy = int'(y_o); hz = int'(z_o);
      moved = 0;
      for (int i = 0; i < 8; i++) begin
         mode_i = ~mode_i; x_i = 8'(i * 17); y_i = 8'(-i * 9); z_i = 8'(i * 13);
         @(negedge clk);
         if (int'(x_o) != hx || int'(y_o) != hy || int'(z_o) != hz || done_o) moved++;
      end
      check_eq("R10", "results held", moved, 0);
   endtask

   initial begin
      #2_000_000ns;
      if (!finished) begin
         n_errs++;
         $display("FAIL watchdog expired actual=hung expected=finish");
         $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_anchor();
      t_rotate();
      t_vector();
      t_saturate();
      t_busy_ignore();
      t_back_to_back();
      t_hold();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
   end

endmodule